// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches the pins of several eight-bit input ports and turns selected signal transitions into interrupt events. Every pin owns three control bits: an enable, a polarity choice (rising or falling transition) and a sticky pending flag. Pin inputs first pass through a two-flop synchronizer. A registered copy of the previous synchronized sample is then compared with the current one. When a transition of the chosen polarity shows up, the pin's pending flag is set. This happens whether or not the pin's enable is on.

Pending flags that are also enabled are ORed into one interrupt request. That request only reaches the output when two control bits are both set: a module mask bit and a global enable bit. Any detected transition on any pin also produces a one-cycle wake pulse. The surrounding system uses it to leave its low-power stop mode and return to the normal clock. Software reaches every register through a plain single-cycle write strobe, an address and a combinational read-data output.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, all enable, polarity and flag bits read 0, the mask and global enable bits read 0, and irq_o and wake_o are low.
- R2: The register address is formed as {port index, kind}. Kind is bus_addr[1:0]: 0 selects the enable register, 1 the polarity register and 2 the flag register. Kind 3 at port index 0 is the control register, with bit 0 as the module mask and bit 1 as the global enable. A write with bus_wr high is applied at the next rising clock edge. bus_rdata is a combinational read of the addressed register.
- R3: A polarity bit of 0 selects rising transitions and 1 selects falling transitions. Suppose a pin changes before rising edge k and is then held. Its flag and the wake pulse then appear after edge k+2, and not earlier.
- R4: A detected transition sets the pin's flag even when that pin's enable bit is 0.
- R5: Flags are sticky. Writing a 1 to a flag bit has no effect. Writing a 0 clears it.
- R6: If a transition is detected in the same cycle as a write that clears that flag, the flag stays set.
- R7: irq_o is high exactly when some pin has both its flag and its enable set, and the mask bit and global enable bit are both 1.
- R8: wake_o pulses high for one cycle after any cycle in which a transition is detected, regardless of enables, mask or global enable.
- R9: Changing a polarity bit while the pin is steady sets no flag and gives no wake pulse.
- R10: Control register bits above bit 1 read 0. Kind 3 at a nonzero port index reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPORTS*PW | Asynchronous pin inputs, port p at bits [p*PW +: PW] |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address {port, kind} |
| bus_wdata | input | PW | Write data |
| bus_rdata | output | PW | Read data for bus_addr |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | One-cycle stop-mode wake pulse |

## Verification
The bench times a transition to arrive in exactly the cycle that software clears the flag. A design that gave the clear priority would lose that event. It also toggles a polarity bit while the pin is steady. A design that compared the raw pin against the polarity, or retimed the polarity bit into the detector, would report a false event here. Falling-edge detection is checked cycle by cycle, so that a missing or extra synchronizer stage shows up as a flag one cycle early or late. Flags on disabled pins are checked to still record transitions. The request is checked against every combination of mask and global enable, which catches a design that ignores either bit.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    KIND_EN   = 2'd0,
    KIND_SEL  = 2'd1,
    KIND_FLAG = 2'd2,
    KIND_CTRL = 2'd3
  } reg_kind_e;

  localparam int CTRL_MASK_BIT = 0;
  localparam int CTRL_GEN_BIT  = 1;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign cur  = stage2_q;
  assign prev = prev_q;

  // R3
  prev_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev == $past(cur)));
endmodule

// File: rtl/eirq_port_bank.sv
module eirq_port_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic         wr_flag,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] sel_q,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] hit
);
  logic [W-1:0] rise, fall, flag_d;

  always_comb begin
    rise = cur & ~prev;
    fall = ~cur & prev;
    hit  = (sel_q & fall) | (~sel_q & rise);
    if (wr_flag) flag_d = (flag_q & wdata) | hit;
    else         flag_d = flag_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en)  en_q  <= wdata;
      if (wr_sel) sel_q <= wdata;
      flag_q <= flag_d;
    end
  end

  // R4
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit)));

  // R5
  flag_rise_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0));

  // R9
  steady_pin_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == prev) |=> ((flag_q & ~$past(flag_q)) == '0));

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/eirq_global.sv
module eirq_global #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  input  logic         pending,
  input  logic         any_hit,
  output logic         mask_q,
  output logic         gen_q,
  output logic         irq,
  output logic         wake
);
  import eirq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      gen_q  <= 1'b0;
      wake   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mask_q <= wdata[CTRL_MASK_BIT];
        gen_q  <= wdata[CTRL_GEN_BIT];
      end
      wake <= any_hit;
    end
  end

  assign irq = pending & mask_q & gen_q;

  // R8
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !any_hit) |=> !wake);
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl #(
  parameter  int NPORTS  = 2,
  parameter  int PW      = 8,
  localparam int PORT_AW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int AW      = PORT_AW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS*PW-1:0] pin_i,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [PW-1:0]        bus_wdata,
  output logic [PW-1:0]        bus_rdata,
  output logic                 irq_o,
  output logic                 wake_o
);
  import eirq_pkg::*;

  logic [PW-1:0] en_a   [NPORTS];
  logic [PW-1:0] sel_a  [NPORTS];
  logic [PW-1:0] flag_a [NPORTS];
  logic [PW-1:0] hit_a  [NPORTS];
  logic [NPORTS*PW-1:0] hit_all;
  logic [PORT_AW-1:0] port_idx;
  reg_kind_e kind;
  logic pending, mask_q, gen_q, wr_ctrl;

  assign port_idx = bus_addr[AW-1:2];
  assign kind     = reg_kind_e'(bus_addr[1:0]);
  assign wr_ctrl  = bus_wr && (kind == KIND_CTRL) && (port_idx == '0);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [PW-1:0] cur, prev;
    logic hit_me;
    assign hit_me = bus_wr && (port_idx == PORT_AW'(p));

    eirq_sync #(.W(PW)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .pin (pin_i[p*PW +: PW]),
      .cur (cur), .prev (prev)
    );

    eirq_port_bank #(.W(PW)) u_bank (
      .clk (clk), .rst_n (rst_n),
      .cur (cur), .prev (prev),
      .wr_en   (hit_me && kind == KIND_EN),
      .wr_sel  (hit_me && kind == KIND_SEL),
      .wr_flag (hit_me && kind == KIND_FLAG),
      .wdata   (bus_wdata),
      .en_q (en_a[p]), .sel_q (sel_a[p]), .flag_q (flag_a[p]), .hit (hit_a[p])
    );

    assign hit_all[p*PW +: PW] = hit_a[p];
  end

  always_comb begin
    pending = 1'b0;
    for (int p = 0; p < NPORTS; p++) pending = pending | (|(flag_a[p] & en_a[p]));
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (port_idx == PORT_AW'(p)) begin
        case (kind)
          KIND_EN:   bus_rdata = en_a[p];
          KIND_SEL:  bus_rdata = sel_a[p];
          KIND_FLAG: bus_rdata = flag_a[p];
          default:   if (p == 0) bus_rdata = PW'({gen_q, mask_q});
        endcase
      end
    end
  end

  eirq_global #(.W(PW)) u_global (
    .clk (clk), .rst_n (rst_n),
    .wr_ctrl (wr_ctrl), .wdata (bus_wdata),
    .pending (pending), .any_hit (|hit_all),
    .mask_q (mask_q), .gen_q (gen_q),
    .irq (irq_o), .wake (wake_o)
  );

  // R8
  wake_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_all) |=> wake_o);

  // R8
  no_wake_without_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit_all) |=> !wake_o);

  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q && gen_q && pending));
endmodule

// File: tb/eirq_ctrl_test.sv
module eirq_ctrl_test;
  localparam int NP = 2;
  localparam int PW = 8;
  localparam int AW = 3;
  localparam int NB = NP * PW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] pin_i = '0;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [PW-1:0] bus_wdata = '0;
  logic [PW-1:0] bus_rdata;
  logic irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NB-1:0] m_s1, m_s2, m_pv, m_en, m_sel, m_flag;
  logic m_mask, m_gen, m_wake;

  always #5 clk = ~clk;

  eirq_ctrl #(.NPORTS(NP), .PW(PW)) uut (
    .clk (clk), .rst_n (rst_n), .pin_i (pin_i),
    .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .irq_o (irq_o), .wake_o (wake_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [PW-1:0] exp_rd(input logic [AW-1:0] a);
    int p = int'(a[AW-1:2]);
    case (a[1:0])
      2'd0: return m_en[p*PW +: PW];
      2'd1: return m_sel[p*PW +: PW];
      2'd2: return m_flag[p*PW +: PW];
      default: return (p == 0) ? PW'({m_gen, m_mask}) : '0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|(m_flag & m_en)) & m_mask & m_gen;
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    case (a[1:0])
      2'd2: return "R4/R5 flag read";
      2'd3: return "R10 control read";
      default: return "R2 register read";
    endcase
  endfunction

  task automatic model_step();
    logic [NB-1:0] hit;
    int p;
    hit = (m_sel & m_pv & ~m_s2) | (~m_sel & m_s2 & ~m_pv);
    p = int'(bus_addr[AW-1:2]);
    if (bus_wr && bus_addr[1:0] == 2'd2) m_flag[p*PW +: PW] = m_flag[p*PW +: PW] & bus_wdata;
    m_flag = m_flag | hit;
    if (bus_wr && bus_addr[1:0] == 2'd0) m_en[p*PW +: PW] = bus_wdata;
    if (bus_wr && bus_addr[1:0] == 2'd1) m_sel[p*PW +: PW] = bus_wdata;
    if (bus_wr && bus_addr[1:0] == 2'd3 && p == 0) begin
      m_mask = bus_wdata[0];
      m_gen  = bus_wdata[1];
    end
    m_wake = |hit;
    m_pv = m_s2;
    m_s2 = m_s1;
    m_s1 = pin_i;
  endtask

  // Inputs are set at a falling edge; outputs checked, then one rising edge.
  task automatic tick();
    #1;
    chk(bus_rdata === exp_rd(bus_addr), rd_tag(bus_addr), bus_rdata, exp_rd(bus_addr));
    chk(irq_o === exp_irq(), "R7 irq", irq_o, exp_irq());
    chk(wake_o === m_wake, "R8 wake", wake_o, m_wake);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [PW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    bus_wr = 1'b0; bus_addr = a;
    #1;
  endtask

  initial begin
    m_s1 = '0; m_s2 = '0; m_pv = '0; m_en = '0; m_sel = '0; m_flag = '0;
    m_mask = 1'b0; m_gen = 1'b0; m_wake = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(irq_o === 1'b0 && wake_o === 1'b0, "R1 outputs after reset", {irq_o, wake_o}, 0);
    for (int a = 0; a < 8; a++) begin
      bus_addr = AW'(a);
      #1;
      chk(bus_rdata === '0, "R1 register after reset", bus_rdata, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R3: falling-edge pin on port 1 bit 2, exact latency
    wr(3'b101, 8'h04);
    pin_i[10] = 1'b1;
    repeat (4) tick();
    rd(3'b110);
    chk(bus_rdata[2] === 1'b0, "R3 rising ignored with polarity=1", bus_rdata, 0);
    pin_i[10] = 1'b0;
    tick(); tick();
    rd(3'b110);
    chk(bus_rdata[2] === 1'b0, "R3 flag not early", bus_rdata, 0);
    tick();
    rd(3'b110);
    chk(bus_rdata[2] === 1'b1, "R3 falling edge flagged after k+2", bus_rdata, 8'h04);
    chk(wake_o === 1'b1, "R8 wake with flag", wake_o, 1);
    tick();
    chk(wake_o === 1'b0, "R8 wake one cycle", wake_o, 0);
    // R4: enable was 0 for that pin, flag still set
    rd(3'b100);
    chk(bus_rdata === 8'h00, "R4 pin was disabled", bus_rdata, 0);

    // R5: writing ones leaves flag, zero clears
    wr(3'b110, 8'hFF);
    rd(3'b110);
    chk(bus_rdata === 8'h04, "R5 write 1 no effect", bus_rdata, 8'h04);
    wr(3'b110, 8'h00);
    rd(3'b110);
    chk(bus_rdata === 8'h00, "R5 write 0 clears", bus_rdata, 0);

    // R6: rising edge on port 0 bit 0 coincident with clear
    pin_i[0] = 1'b1;
    tick(); tick();
    wr(3'b010, 8'h00);
    rd(3'b010);
    chk(bus_rdata === 8'h01, "R6 edge beats clear", bus_rdata, 8'h01);

    // R7: gating combinations
    wr(3'b000, 8'h01);
    for (int c = 0; c < 4; c++) begin
      wr(3'b011, PW'(c));
      rd(3'b011);
      chk(irq_o === (c == 3), "R7 mask/global combo", irq_o, (c == 3));
    end
    wr(3'b000, 8'h00);
    rd(3'b011);
    chk(irq_o === 1'b0, "R7 enable off", irq_o, 0);

    // R9: polarity toggles with steady pins
    wr(3'b010, 8'h00);
    for (int t = 0; t < 4; t++) begin
      wr(3'b001, (t % 2) ? 8'hFF : 8'h00);
      chk(wake_o === 1'b0, "R9 no wake on polarity change", wake_o, 0);
    end
    repeat (3) tick();
    rd(3'b010);
    chk(bus_rdata === 8'h00, "R9 no flag on polarity change", bus_rdata, 0);

    // R10: reserved control bits and unused address
    wr(3'b011, 8'hFF);
    rd(3'b011);
    chk(bus_rdata === 8'h03, "R10 reserved bits zero", bus_rdata, 8'h03);
    wr(3'b111, 8'h00);
    rd(3'b111);
    chk(bus_rdata === 8'h00, "R10 unused address reads 0", bus_rdata, 0);
    rd(3'b011);
    chk(bus_rdata === 8'h03, "R10 unused write ignored", bus_rdata, 8'h03);

    // Random phase, fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < NB; b++)
        if ($urandom_range(0, 15) == 0) pin_i[b] = ~pin_i[b];
      bus_wr = ($urandom_range(0, 4) == 0);
      bus_addr = AW'($urandom_range(0, 7));
      bus_wdata = PW'($urandom);
      if (bus_addr[1:0] == 2'd2 && $urandom_range(0, 1) == 1) bus_wdata = 8'hFF;
      tick();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule